// File: doc/BRIEF.md
# Half-Bridge Channel Fault Status Manager

This block watches six half-bridge channels and turns raw protection comparator inputs into status. The inputs are per-channel overcurrent, per-channel underload, a thermal warning, a thermal shutdown and supply under- or overvoltage. Each channel has its own overcurrent qualification timer. All channels share one underload qualification timer, so a channel whose underload starts while the timer is already running only waits out the time that is left. From this the block produces:

- three sticky global flags: overcurrent, underload and thermal shutdown;
- two live global flags: supply fault and thermal warning;
- a two-bit status per channel, driven by a small state machine;
- a per-channel request to force the channel's drivers off.

A status-reset request clears the sticky state and lets faulted channels drive again. A reset request that comes too soon after the previous accepted one is dropped. Taking the enable input low wipes all status, as a synchronous reset does.

Top module: `hbflt_top`

## Requirements
- R1: While `rst` is high, or one cycle after `en` is sampled low, every flag, every `ch_stat` field and every `ch_off` bit is 0.
- R2: Channel status is `ch_stat[2i+1:2i]`, with the codes 00 disabled, 01 overcurrent, 10 underload and 11 enabled. A disabled channel that has a drive request, no latched off request and no lockout shows 11 one cycle later. An enabled channel whose drive request drops shows 00 one cycle later.
- R3: Overcurrent on a driven channel sampled for OC_DLY consecutive cycles gives status 01, sets `flg_ocs` and raises that channel's `ch_off`, all visible after the OC_DLY-th sample. A run that is one sample shorter changes nothing. `flg_ocs` stays set until an accepted status reset or enable low.
- R4: A channel in status 01 never moves to status 10. A channel in status 10 that then sees qualified overcurrent moves to 01.
- R5: One shared underload timer counts while any enabled channel reports underload. Each enabled channel that reports underload when the timer reaches UL_DLY samples moves to status 10 and sets `flg_uld`, whenever its own underload began.
- R6: Underload status forces the channel off (`ch_off`=1) only when `uld_sc`=1. With `uld_sc`=0 the channel keeps `ch_off`=0.
- R7: `flg_tw` equals `tw_raw` delayed by one cycle and has no effect on `ch_stat` or `ch_off`.
- R8: `tsd_raw` sets the sticky `flg_tsd` and all `ch_off` bits one cycle later, and all channel status reads 00 two cycles later. The flag and the lockout stay after `tsd_raw` falls.
- R9: `flg_psf` equals `uv_raw | ov_raw` delayed by one cycle and is not sticky. Undervoltage, or overvoltage with `ovlo`=1, forces all `ch_off` one cycle later and all status to 00 two cycles later, and channels come back on their own once the fault clears. Overvoltage with `ovlo`=0 sets `flg_psf` only.
- R10: An accepted status reset clears `flg_ocs`, `flg_uld`, `flg_tsd` and every latched off request. A fault that is still present qualifies again and latches again.
- R11: A status reset sampled fewer than SRR_GAP cycles after the previously accepted one is ignored. One sampled exactly SRR_GAP cycles later is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low clears all status |
| drive_req | input | N_CH | Per-channel drive request (enable bit with any external modulation already merged) |
| uld_sc | input | 1 | 1: underload forces the channel off |
| ovlo | input | 1 | 1: overvoltage locks the outputs out |
| oc_raw | input | N_CH | Per-channel overcurrent comparator |
| ul_raw | input | N_CH | Per-channel underload comparator |
| tw_raw | input | 1 | Thermal warning comparator |
| tsd_raw | input | 1 | Thermal shutdown comparator |
| uv_raw | input | 1 | Supply undervoltage comparator |
| ov_raw | input | 1 | Supply overvoltage comparator |
| srr_req | input | 1 | Status reset request from a valid command frame |
| flg_ocs | output | 1 | Sticky overcurrent flag |
| flg_uld | output | 1 | Sticky underload flag |
| flg_tsd | output | 1 | Sticky thermal shutdown flag |
| flg_psf | output | 1 | Live supply fault flag |
| flg_tw | output | 1 | Live thermal warning flag |
| ch_stat | output | 2*N_CH | Per-channel two-bit status |
| ch_off | output | N_CH | Per-channel forced-off request |

## Verification
The bench builds the block with OC_DLY=8, UL_DLY=12 and SRR_GAP=20, in place of the long defaults. At these values each qualification boundary can be reached in a handful of cycles: the run one sample short of overcurrent qualification, the cycle before and the cycle of a shared underload expiry for a channel that joined five cycles late, and a status reset landing one cycle inside and then exactly at the end of the reset interval. The small values also leave room to re-qualify a persistent fault after a reset within the same short scenario.

// File: rtl/hbflt_pkg.sv
package hbflt_pkg;

    // Per-channel status code; the encoding is visible on ch_stat.
    typedef enum logic [1:0] {
        ST_OFF = 2'b00,
        ST_OVC = 2'b01,
        ST_ULD = 2'b10,
        ST_ON  = 2'b11
    } ch_state_e;

    typedef struct packed {
        logic ocs;
        logic uld;
        logic tsd;
        logic psf;
        logic tw;
    } flags_t;

    // Channel drivers are on in these states (unless forced off).
    function automatic logic st_driving(ch_state_e s);
        return (s == ST_ON) || (s == ST_ULD);
    endfunction

    // Counter width able to hold 0 .. lim-1.
    function automatic int unsigned cnt_w(int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/hbflt_oc_timer.sv
module hbflt_oc_timer #(
    parameter int unsigned DLY = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic oc_in,
    output logic expired
);
    localparam int unsigned W = hbflt_pkg::cnt_w(DLY);

    logic [W-1:0] cnt;

    assign expired = run && oc_in && (cnt == W'(DLY - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || !run || !oc_in || expired)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hbflt_ul_timer.sv
module hbflt_ul_timer #(
    parameter int unsigned N_CH = 6,
    parameter int unsigned DLY  = 25000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [N_CH-1:0] arm,
    output logic [N_CH-1:0] expired
);
    localparam int unsigned W = hbflt_pkg::cnt_w(DLY);

    logic [W-1:0] cnt;
    logic         any_arm;
    logic         done;

    assign any_arm = |arm;
    assign done    = any_arm && (cnt == W'(DLY - 1));
    assign expired = done ? arm : '0;

    always_ff @(posedge clk) begin
        if (rst || clr || !any_arm || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hbflt_srr_gate.sv
module hbflt_srr_gate #(
    parameter int unsigned GAP = 3750
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic req,
    output logic acc
);
    localparam int unsigned W = hbflt_pkg::cnt_w(GAP);

    logic [W-1:0] wait_cnt;

    assign acc = req && !clr && (wait_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || clr)
            wait_cnt <= '0;
        else if (acc)
            wait_cnt <= W'(GAP - 1);
        else if (wait_cnt != '0)
            wait_cnt <= wait_cnt - 1'b1;
    end
endmodule

// File: rtl/hbflt_chan.sv
module hbflt_chan
    import hbflt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      srr,
    input  logic      lock,
    input  logic      drive_req,
    input  logic      oc_exp,
    input  logic      ul_exp,
    input  logic      uld_sc,
    output ch_state_e st,
    output logic      off_lat
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st      <= ST_OFF;
            off_lat <= 1'b0;
        end else if (srr) begin
            st      <= ST_OFF;
            off_lat <= 1'b0;
        end else begin
            if (oc_exp || (ul_exp && uld_sc))
                off_lat <= 1'b1;
            if (lock) begin
                st <= ST_OFF;
            end else begin
                unique case (st)
                    ST_OFF: if (drive_req && !off_lat) st <= ST_ON;
                    ST_ON: begin
                        if (!drive_req)  st <= ST_OFF;
                        else if (oc_exp) st <= ST_OVC;
                        else if (ul_exp) st <= ST_ULD;
                    end
                    ST_ULD: begin
                        if (oc_exp)          st <= ST_OVC;
                        else if (!drive_req) st <= ST_OFF;
                    end
                    ST_OVC: st <= ST_OVC;
                endcase
            end
        end
    end
endmodule

// File: rtl/hbflt_top.sv
module hbflt_top
    import hbflt_pkg::*;
#(
    parameter int unsigned N_CH    = 6,
    parameter int unsigned OC_DLY  = 2500,
    parameter int unsigned UL_DLY  = 25000,
    parameter int unsigned SRR_GAP = 3750
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [N_CH-1:0]   drive_req,
    input  logic              uld_sc,
    input  logic              ovlo,
    input  logic [N_CH-1:0]   oc_raw,
    input  logic [N_CH-1:0]   ul_raw,
    input  logic              tw_raw,
    input  logic              tsd_raw,
    input  logic              uv_raw,
    input  logic              ov_raw,
    input  logic              srr_req,
    output logic              flg_ocs,
    output logic              flg_uld,
    output logic              flg_tsd,
    output logic              flg_psf,
    output logic              flg_tw,
    output logic [2*N_CH-1:0] ch_stat,
    output logic [N_CH-1:0]   ch_off
);
    flags_t          flg_q;
    logic            lock_q;
    logic            srr_acc;
    logic            clr;
    ch_state_e       st [N_CH];
    logic [N_CH-1:0] off_lat;
    logic [N_CH-1:0] active;
    logic [N_CH-1:0] ul_arm;
    logic [N_CH-1:0] oc_exp;
    logic [N_CH-1:0] ul_exp;

    assign clr = !en;

    hbflt_srr_gate #(.GAP(SRR_GAP)) u_srr (
        .clk(clk), .rst(rst), .clr(clr), .req(srr_req), .acc(srr_acc)
    );

    hbflt_ul_timer #(.N_CH(N_CH), .DLY(UL_DLY)) u_ult (
        .clk(clk), .rst(rst), .clr(clr), .arm(ul_arm), .expired(ul_exp)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign ch_off[i] = off_lat[i] | flg_q.tsd | lock_q;
        assign active[i] = st_driving(st[i]) && !ch_off[i];
        assign ul_arm[i] = ul_raw[i] && (st[i] == ST_ON) && !ch_off[i];
        assign ch_stat[2*i +: 2] = st[i];

        hbflt_oc_timer #(.DLY(OC_DLY)) u_oct (
            .clk(clk), .rst(rst), .clr(clr),
            .run(active[i]), .oc_in(oc_raw[i]), .expired(oc_exp[i])
        );

        hbflt_chan u_chan (
            .clk(clk), .rst(rst), .en(en), .srr(srr_acc),
            .lock(lock_q | flg_q.tsd), .drive_req(drive_req[i]),
            .oc_exp(oc_exp[i]), .ul_exp(ul_exp[i]), .uld_sc(uld_sc),
            .st(st[i]), .off_lat(off_lat[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flg_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            flg_q.psf <= uv_raw | ov_raw;
            flg_q.tw  <= tw_raw;
            lock_q    <= uv_raw | (ov_raw & ovlo);
            flg_q.tsd <= srr_acc ? tsd_raw : (flg_q.tsd | tsd_raw);
            flg_q.ocs <= srr_acc ? 1'b0 : (flg_q.ocs | (|oc_exp));
            flg_q.uld <= srr_acc ? 1'b0 : (flg_q.uld | (|ul_exp));
        end
    end

    assign flg_ocs = flg_q.ocs;
    assign flg_uld = flg_q.uld;
    assign flg_tsd = flg_q.tsd;
    assign flg_psf = flg_q.psf;
    assign flg_tw  = flg_q.tw;
endmodule

// File: rtl/hbflt_chk.sv
module hbflt_chk #(
    parameter int unsigned N_CH    = 6,
    parameter int unsigned SRR_GAP = 3750
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              tw_raw,
    input logic              uv_raw,
    input logic              ov_raw,
    input logic              srr_acc,
    input logic              flg_ocs,
    input logic              flg_uld,
    input logic              flg_tsd,
    input logic              flg_psf,
    input logic              flg_tw,
    input logic [2*N_CH-1:0] ch_stat,
    input logic [N_CH-1:0]   ch_off
);
    localparam int unsigned GW = $clog2(SRR_GAP + 1);

    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst || !en)
            gap <= GW'(SRR_GAP);
        else if (srr_acc)
            gap <= GW'(1);
        else if (gap < GW'(SRR_GAP))
            gap <= gap + 1'b1;
    end

    AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ch_stat == '0 && ch_off == '0 && !flg_ocs && !flg_uld
                 && !flg_tsd && !flg_psf && !flg_tw)); // R1

    AST_OCS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (en && flg_ocs && !srr_acc) |=> flg_ocs); // R3

    AST_TW_TRACKS: assert property (@(posedge clk) disable iff (rst)
        en |=> (flg_tw == $past(tw_raw))); // R7

    AST_TSD_DISABLES: assert property (@(posedge clk) disable iff (rst)
        (flg_tsd && $past(flg_tsd)) |-> (ch_stat == '0 && ch_off == '1)); // R8

    AST_PSF_TRACKS: assert property (@(posedge clk) disable iff (rst)
        en |=> (flg_psf == $past(uv_raw | ov_raw))); // R9

    AST_SRR_SPACING: assert property (@(posedge clk) disable iff (rst)
        srr_acc |-> (gap >= GW'(SRR_GAP))); // R11

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        AST_NO_OVC_TO_ULD: assert property (@(posedge clk) disable iff (rst)
            (ch_stat[2*i +: 2] == 2'b01) |=> (ch_stat[2*i +: 2] != 2'b10)); // R4
    end
endmodule

bind hbflt_top hbflt_chk #(.N_CH(N_CH), .SRR_GAP(SRR_GAP)) u_chk (
    .clk(clk), .rst(rst), .en(en), .tw_raw(tw_raw), .uv_raw(uv_raw),
    .ov_raw(ov_raw), .srr_acc(srr_acc), .flg_ocs(flg_ocs), .flg_uld(flg_uld),
    .flg_tsd(flg_tsd), .flg_psf(flg_psf), .flg_tw(flg_tw),
    .ch_stat(ch_stat), .ch_off(ch_off)
);

// File: tb/sim_hbflt_top.sv
module sim_hbflt_top;
    localparam int N   = 6;
    localparam int OCD = 8;
    localparam int ULD = 12;
    localparam int GAP = 20;

    logic           clk = 1'b0;
    logic           rst, en, uld_sc, ovlo, tw_raw, tsd_raw, uv_raw, ov_raw, srr_req;
    logic [N-1:0]   drive_req, oc_raw, ul_raw;
    logic           flg_ocs, flg_uld, flg_tsd, flg_psf, flg_tw;
    logic [2*N-1:0] ch_stat;
    logic [N-1:0]   ch_off;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    hbflt_top #(.N_CH(N), .OC_DLY(OCD), .UL_DLY(ULD), .SRR_GAP(GAP)) u0 (
        .clk(clk), .rst(rst), .en(en), .drive_req(drive_req), .uld_sc(uld_sc),
        .ovlo(ovlo), .oc_raw(oc_raw), .ul_raw(ul_raw), .tw_raw(tw_raw),
        .tsd_raw(tsd_raw), .uv_raw(uv_raw), .ov_raw(ov_raw), .srr_req(srr_req),
        .flg_ocs(flg_ocs), .flg_uld(flg_uld), .flg_tsd(flg_tsd),
        .flg_psf(flg_psf), .flg_tw(flg_tw), .ch_stat(ch_stat), .ch_off(ch_off)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] st_of(input int ch);
        return ch_stat[2*ch +: 2];
    endfunction

    task automatic restart();
        en = 1'b0; oc_raw = '0; ul_raw = '0; tw_raw = 1'b0; tsd_raw = 1'b0;
        uv_raw = 1'b0; ov_raw = 1'b0; srr_req = 1'b0; uld_sc = 1'b0; ovlo = 1'b0;
        step(1);
        en = 1'b1; drive_req = '1;
        step(1);
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b0; drive_req = '0; oc_raw = '0; ul_raw = '0;
        uld_sc = 1'b0; ovlo = 1'b0; tw_raw = 1'b0; tsd_raw = 1'b0;
        uv_raw = 1'b0; ov_raw = 1'b0; srr_req = 1'b0;
        step(3);
        chk("R1 reset ch_stat", 32'(ch_stat), 0);
        chk("R1 reset ch_off", 32'(ch_off), 0);
        chk("R1 reset flags", {27'd0, flg_ocs, flg_uld, flg_tsd, flg_psf, flg_tw}, 0);
        rst = 1'b0;
    endtask

    task automatic t_enable();
        en = 1'b1; drive_req = '1;
        step(1);
        chk("R2 all enabled", 32'(ch_stat), 32'hFFF);
        chk("R2 no off request", 32'(ch_off), 0);
        drive_req[3] = 1'b0;
        step(1);
        chk("R2 request drop", 32'(st_of(3)), 0);
        drive_req[3] = 1'b1;
        step(1);
        chk("R2 request back", 32'(st_of(3)), 3);
    endtask

    task automatic t_overcurrent();
        oc_raw[2] = 1'b1;
        step(OCD - 1);
        oc_raw[2] = 1'b0;
        step(1);
        chk("R3 short burst status", 32'(st_of(2)), 3);
        chk("R3 short burst flag", 32'(flg_ocs), 0);
        oc_raw[2] = 1'b1;
        step(OCD - 1);
        chk("R3 before expiry", 32'(st_of(2)), 3);
        step(1);
        chk("R3 status 01", 32'(st_of(2)), 1);
        chk("R3 flag set", 32'(flg_ocs), 1);
        chk("R3 ch_off", 32'(ch_off), 32'h04);
        oc_raw[2] = 1'b0;
        ul_raw[2] = 1'b1;
        step(ULD + 2);
        chk("R4 no path to underload", 32'(st_of(2)), 1);
        chk("R4 uld flag untouched", 32'(flg_uld), 0);
        chk("R3 flag sticky", 32'(flg_ocs), 1);
        restart();
    endtask

    task automatic t_underload();
        uld_sc = 1'b0;
        ul_raw[0] = 1'b1;
        step(5);
        ul_raw[4] = 1'b1;
        step(ULD - 6);
        chk("R5 ch0 before expiry", 32'(st_of(0)), 3);
        chk("R5 ch4 before expiry", 32'(st_of(4)), 3);
        step(1);
        chk("R5 ch0 status 10", 32'(st_of(0)), 2);
        chk("R5 ch4 inherits remaining time", 32'(st_of(4)), 2);
        chk("R5 uld flag", 32'(flg_uld), 1);
        chk("R6 stays driven with uld_sc=0", 32'(ch_off), 0);
        oc_raw[0] = 1'b1;
        step(OCD);
        chk("R4 underload to overcurrent", 32'(st_of(0)), 1);
        restart();
        uld_sc = 1'b1;
        ul_raw[1] = 1'b1;
        step(ULD);
        chk("R5 single channel", 32'(st_of(1)), 2);
        chk("R6 forced off with uld_sc=1", 32'(ch_off), 32'h02);
        restart();
    endtask

    task automatic t_warning();
        tw_raw = 1'b1;
        step(1);
        chk("R7 warning set", 32'(flg_tw), 1);
        chk("R7 status untouched", 32'(ch_stat), 32'hFFF);
        chk("R7 outputs untouched", 32'(ch_off), 0);
        tw_raw = 1'b0;
        step(1);
        chk("R7 warning cleared", 32'(flg_tw), 0);
    endtask

    task automatic t_thermal();
        tsd_raw = 1'b1;
        step(1);
        chk("R8 all forced off", 32'(ch_off), 32'h3F);
        step(1);
        chk("R8 flag set", 32'(flg_tsd), 1);
        chk("R8 status cleared", 32'(ch_stat), 0);
        tsd_raw = 1'b0;
        step(3);
        chk("R8 flag sticky", 32'(flg_tsd), 1);
        chk("R8 still locked", 32'(ch_stat), 0);
        srr_req = 1'b1;
        step(1);
        srr_req = 1'b0;
        chk("R10 tsd cleared", 32'(flg_tsd), 0);
        step(1);
        chk("R10 channels resume", 32'(ch_stat), 32'hFFF);
        restart();
    endtask

    task automatic t_supply();
        uv_raw = 1'b1;
        step(1);
        chk("R9 uv lockout", 32'(ch_off), 32'h3F);
        step(1);
        chk("R9 psf set", 32'(flg_psf), 1);
        chk("R9 status cleared", 32'(ch_stat), 0);
        uv_raw = 1'b0;
        step(1);
        chk("R9 psf clears", 32'(flg_psf), 0);
        step(1);
        chk("R9 auto recovery", 32'(ch_stat), 32'hFFF);
        ovlo = 1'b0; ov_raw = 1'b1;
        step(2);
        chk("R9 ov psf with ovlo=0", 32'(flg_psf), 1);
        chk("R9 ov no lockout", 32'(ch_stat), 32'hFFF);
        chk("R9 ov no off", 32'(ch_off), 0);
        ovlo = 1'b1;
        step(2);
        chk("R9 ov lockout with ovlo=1", 32'(ch_stat), 0);
        ov_raw = 1'b0; ovlo = 1'b0;
        step(2);
        chk("R9 ov recovery", 32'(ch_stat), 32'hFFF);
    endtask

    task automatic t_relatch();
        oc_raw[5] = 1'b1;
        step(OCD);
        chk("R3 ch5 latched", 32'(st_of(5)), 1);
        srr_req = 1'b1;
        step(1);
        srr_req = 1'b0;
        chk("R10 ocs cleared", 32'(flg_ocs), 0);
        chk("R10 off request cleared", 32'(ch_off), 0);
        step(OCD);
        chk("R10 re-enabled", 32'(st_of(5)), 3);
        chk("R10 not yet relatched", 32'(flg_ocs), 0);
        step(1);
        chk("R10 relatched status", 32'(st_of(5)), 1);
        chk("R10 relatched flag", 32'(flg_ocs), 1);
        restart();
    endtask

    task automatic t_srr_gap();
        oc_raw[1] = 1'b1;
        step(OCD);
        oc_raw[1] = 1'b0;
        chk("R3 ch1 flag", 32'(flg_ocs), 1);
        srr_req = 1'b1;
        step(1);
        srr_req = 1'b0;
        chk("R11 first reset accepted", 32'(flg_ocs), 0);
        oc_raw[1] = 1'b1;
        step(OCD + 1);
        oc_raw[1] = 1'b0;
        chk("R11 fault again", 32'(flg_ocs), 1);
        step(GAP - 2 - (OCD + 1));
        srr_req = 1'b1;
        step(1);
        chk("R11 early reset ignored", 32'(flg_ocs), 1);
        step(1);
        srr_req = 1'b0;
        chk("R11 reset at interval accepted", 32'(flg_ocs), 0);
        restart();
    endtask

    task automatic t_enable_low();
        tsd_raw = 1'b1; tw_raw = 1'b1; uv_raw = 1'b1;
        step(2);
        en = 1'b0;
        step(1);
        chk("R1 en low status", 32'(ch_stat), 0);
        chk("R1 en low off", 32'(ch_off), 0);
        chk("R1 en low flags", {27'd0, flg_ocs, flg_uld, flg_tsd, flg_psf, flg_tw}, 0);
        restart();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
    end

    initial begin
        t_reset();
        t_enable();
        t_overcurrent();
        t_underload();
        t_warning();
        t_thermal();
        t_supply();
        t_relatch();
        t_srr_gap();
        t_enable_low();
        summary();
    end
endmodule